// File: doc/BRIEF.md
# PLL Lock Status Qualifier

This block merges the raw lock indicators of one transmit clock multiplier and a set of receive clock-recovery loops into one debounced, active-high lock status. Every raw indicator is first brought into the reference-clock domain through a two-flop synchronizer. The combined condition "every indicator is good" must then hold without a break for a full assert window before the status goes high. Once the status is high, a bad condition (any one indicator low) must hold without a break for a longer deassert window before the status drops. A single counter measures whichever window applies, and it restarts whenever the condition breaks, so a glitch shorter than the window never moves the output.

An external active-low reset is filtered: a low level has an effect only after it has been seen low for four consecutive reference cycles. A qualified reset clears the status. Because the counter also restarts, the status cannot return high until a full assert window has passed after the reset is released. The status is meant to drive the enable of an open-drain pad whose low level is driven actively, so several devices can share one wired-AND line. Both window lengths are parameters. Their defaults, 49,250 and 131,625 cycles, match 394 µs and 1053 µs at a 125 MHz reference.

Top module: `lock_status_qualifier`

## Requirements
- R1: While the reset is qualified, and after it, `lock_ok` is 0 until a full assert window of good indicators has elapsed.
- R2: With `lock_ok` low, after all indicators first become high and stay high, `lock_ok` rises on the (ASSERT_CYC+2)-th rising clock edge counted from the first edge that samples them high. It is still 0 after the edge before that.
- R3: A low level of any indicator during the assert window, even for one cycle, restarts the count. `lock_ok` then rises ASSERT_CYC+2 edges after the first edge that again samples all indicators high.
- R4: With `lock_ok` high, after any indicator goes low and stays low, `lock_ok` falls on the (DEASSERT_CYC+2)-th rising edge counted from the first edge that samples it low. It is still 1 after the edge before that.
- R5: If all indicators are high again before the deassert window ends, the count restarts and `lock_ok` stays 1.
- R6: The bad condition counts as continuous while at least one indicator is low, even if the particular indicator that is low changes during the window.
- R7: A low `rst_n` held for at least 4 consecutive cycles forces `lock_ok` to 0 on the 7th rising edge counted from the first edge that samples `rst_n` low.
- R8: A low pulse on `rst_n` of 3 cycles or fewer has no effect on `lock_ok`.
- R9: After a qualified reset is released with all indicators high, `lock_ok` rises on the (ASSERT_CYC+3)-th edge counted from the first edge that samples `rst_n` high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (125 MHz) |
| rst_n | input | 1 | External active-low reset; filtered to a minimum of 4 cycles |
| tx_pll_lock | input | 1 | Raw lock indicator of the transmit clock multiplier (asynchronous) |
| rx_pll_lock | input | NUM_RX (2) | Raw lock indicators of the receive clock-recovery loops (asynchronous) |
| lock_ok | output | 1 | Qualified lock status; 1 = locked, 0 = open-drain pad pulls the line low |

## Verification
The hardest situation to reach from the ports is a break in the condition that falls strictly inside a qualification window. A one-cycle dip during the assert window, or a brief recovery during the deassert window, must restart the count without the output moving. The stimulus therefore uses short window parameters. It places a single-cycle dip ten cycles into an assert window and checks that nothing happens at the original deadline, and that the rise comes one full window after the recovery. It also hands the bad condition from one receive indicator to another in the same cycle, so the deassert count never sees a good cycle. Reset pulses of exactly three and exactly four cycles exercise both sides of the filter boundary.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  localparam int unsigned LQ_ASSERT_DEF   = 49250;
  localparam int unsigned LQ_DEASSERT_DEF = 131625;
  localparam int unsigned LQ_SYNC_STAGES  = 2;
  localparam int unsigned LQ_RST_MIN_LOW  = 4;

  typedef enum logic {
    LQ_DOWN = 1'b0,
    LQ_UP   = 1'b1
  } lq_state_e;
endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lockq_rst_filter.sv
module lockq_rst_filter #(
  parameter int unsigned MIN_LOW = 4,
  parameter int unsigned STAGES  = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_act
);
  logic          rst_s;
  logic [MIN_LOW-1:0] hist_q;
  logic [MIN_LOW-1:0] hist_d;

  lockq_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .d   (rst_in_n),
    .q   (rst_s)
  );

  always_comb begin
    hist_d = {hist_q[MIN_LOW-2:0], rst_s};
  end

  always_ff @(posedge clk) begin
    hist_q <= hist_d;
  end

  // reset acts only when the last MIN_LOW synchronized samples were all low
  assign rst_act = ~|hist_q;

  // R8: a reset that just became active must have seen a low sample one cycle earlier
  p_filter_low_seen_r8: assert property (@(posedge clk)
    $rose(rst_act) |-> !$past(rst_s));
endmodule

// File: rtl/lockq_qual.sv
module lockq_qual
  import lockq_pkg::*;
#(
  parameter int unsigned ASSERT_CYC   = LQ_ASSERT_DEF,
  parameter int unsigned DEASSERT_CYC = LQ_DEASSERT_DEF
) (
  input  logic clk,
  input  logic clr,
  input  logic all_good,
  output logic status
);
  localparam int unsigned MAXC = (ASSERT_CYC > DEASSERT_CYC) ? ASSERT_CYC : DEASSERT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] A_LIM = CW'(ASSERT_CYC - 1);
  localparam logic [CW-1:0] D_LIM = CW'(DEASSERT_CYC - 1);

  lq_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cond_hit;
  logic [CW-1:0] limit;

  always_comb begin
    cond_hit = (state_q == LQ_DOWN) ? all_good : !all_good;
    limit    = (state_q == LQ_DOWN) ? A_LIM : D_LIM;
    state_d  = state_q;
    cnt_d    = cnt_q;
    if (clr) begin
      state_d = LQ_DOWN;
      cnt_d   = '0;
    end else if (!cond_hit) begin
      cnt_d = '0;
    end else if (cnt_q == limit) begin
      state_d = (state_q == LQ_DOWN) ? LQ_UP : LQ_DOWN;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
    cnt_q   <= cnt_d;
  end

  assign status = (state_q == LQ_UP);

  // R2: a rise only follows a cycle in which all indicators were good
  p_rise_after_good_r2: assert property (@(posedge clk) disable iff (clr)
    $rose(status) |-> $past(all_good));

  // R3: while low, any bad cycle keeps the status low next cycle
  p_bad_blocks_rise_r3: assert property (@(posedge clk) disable iff (clr)
    (!status && !all_good) |=> !status);

  // R4: a fall without reset only follows a bad cycle
  p_fall_after_bad_r4: assert property (@(posedge clk) disable iff (clr)
    ($fell(status) && !$past(clr)) |-> !$past(all_good));

  // R5: while high, a good cycle keeps the status high next cycle
  p_good_holds_r5: assert property (@(posedge clk) disable iff (clr)
    (status && all_good) |=> status);
endmodule

// File: rtl/lock_status_qualifier.sv
module lock_status_qualifier
  import lockq_pkg::*;
#(
  parameter int unsigned NUM_RX       = 2,
  parameter int unsigned ASSERT_CYC   = LQ_ASSERT_DEF,
  parameter int unsigned DEASSERT_CYC = LQ_DEASSERT_DEF,
  parameter int unsigned SYNC_STAGES  = LQ_SYNC_STAGES,
  parameter int unsigned RST_MIN_LOW  = LQ_RST_MIN_LOW
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              tx_pll_lock,
  input  logic [NUM_RX-1:0] rx_pll_lock,
  output logic              lock_ok
);
  localparam int unsigned NLOCK = NUM_RX + 1;

  logic [NLOCK-1:0] raw_lock;
  logic [NLOCK-1:0] lock_s;
  logic             rst_act;
  logic             all_good;

  assign raw_lock = {rx_pll_lock, tx_pll_lock};

  lockq_sync #(.WIDTH(NLOCK), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk (clk_ref),
    .d   (raw_lock),
    .q   (lock_s)
  );

  lockq_rst_filter #(.MIN_LOW(RST_MIN_LOW), .STAGES(SYNC_STAGES)) u_rst_filt (
    .clk      (clk_ref),
    .rst_in_n (rst_n),
    .rst_act  (rst_act)
  );

  assign all_good = &lock_s;

  lockq_qual #(.ASSERT_CYC(ASSERT_CYC), .DEASSERT_CYC(DEASSERT_CYC)) u_qual (
    .clk      (clk_ref),
    .clr      (rst_act),
    .all_good (all_good),
    .status   (lock_ok)
  );

  // R7: a qualified reset drives the status low by the next cycle
  p_reset_clears_r7: assert property (@(posedge clk_ref)
    rst_act |=> !lock_ok);

  // R1: the status never rises in the cycle right after a qualified reset
  p_no_rise_after_reset_r1: assert property (@(posedge clk_ref)
    $past(rst_act) |-> !$rose(lock_ok));
endmodule

// File: tb/sim_lock_status_qualifier.sv
module sim_lock_status_qualifier;
  localparam int unsigned A = 20;
  localparam int unsigned D = 30;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       tx_pll_lock;
  logic [1:0] rx_pll_lock;
  logic       lock_ok;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   ncyc   = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always #4 clk_ref = ~clk_ref;
  always @(posedge clk_ref) ncyc <= ncyc + 1;

  lock_status_qualifier #(.NUM_RX(2), .ASSERT_CYC(A), .DEASSERT_CYC(D)) u0 (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .tx_pll_lock (tx_pll_lock),
    .rx_pll_lock (rx_pll_lock),
    .lock_ok     (lock_ok)
  );

  // monitor: compare queued expectations at the matching cycle
  always @(negedge clk_ref) begin
    while (q.size() > 0 && q[0].cyc <= ncyc) begin
      checks++;
      if (lock_ok !== q[0].val) begin
        errors++;
        $display("FAIL %s cycle %0d: lock_ok=%b expected %b", q[0].tag, ncyc, lock_ok, q[0].val);
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_at(input int base, input int k, input logic v, input string tag);
    exp_t e;
    e.cyc = base + k;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk_ref);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_ref);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    int n1;
    rst_n       = 1'b0;
    tx_pll_lock = 1'b0;
    rx_pll_lock = 2'b00;
    wait_n(10);
    expect_at(ncyc, 1, 1'b0, "R1 reset state");
    settle();
    rst_n = 1'b1;
    wait_n(10);
    expect_at(ncyc, 1, 1'b0, "R1 idle after reset");
    settle();

    // R2: assertion exactly at threshold
    n0 = ncyc;
    tx_pll_lock = 1'b1; rx_pll_lock = 2'b11;
    expect_at(n0, A + 1, 1'b0, "R2 one edge early");
    expect_at(n0, A + 2, 1'b1, "R2 at threshold");
    settle();

    // R4: deassertion exactly at threshold
    wait_n(3);
    n0 = ncyc;
    rx_pll_lock[1] = 1'b0;
    expect_at(n0, D + 1, 1'b1, "R4 one edge early");
    expect_at(n0, D + 2, 1'b0, "R4 at threshold");
    settle();

    // R3: one-cycle glitch mid assert window restarts the count
    wait_n(3);
    n0 = ncyc;
    rx_pll_lock = 2'b11;
    expect_at(n0, A + 2, 1'b0, "R3 original deadline ignored");
    wait_n(10);
    tx_pll_lock = 1'b0;
    wait_n(1);
    n1 = ncyc;
    tx_pll_lock = 1'b1;
    expect_at(n1, A + 1, 1'b0, "R3 restarted one edge early");
    expect_at(n1, A + 2, 1'b1, "R3 restarted threshold");
    settle();

    // R5: recovery inside deassert window keeps status high
    wait_n(3);
    n0 = ncyc;
    rx_pll_lock[0] = 1'b0;
    wait_n(10);
    n1 = ncyc;
    rx_pll_lock[0] = 1'b1;
    expect_at(n0, D + 2, 1'b1, "R5 original deadline ignored");
    expect_at(n1, D + 5, 1'b1, "R5 stays high");
    settle();

    // R6: bad condition handed between indicators counts continuously
    n0 = ncyc;
    rx_pll_lock[0] = 1'b0;
    wait_n(10);
    rx_pll_lock = 2'b01;
    expect_at(n0, D + 1, 1'b1, "R6 one edge early");
    expect_at(n0, D + 2, 1'b0, "R6 continuous bad window");
    settle();

    // bring status back up
    rx_pll_lock = 2'b11;
    wait_n(A + 6);
    expect_at(ncyc, 1, 1'b1, "R2 relocked");
    settle();

    // R8: three-cycle reset pulse is ignored
    n0 = ncyc;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    expect_at(n0, 10, 1'b1, "R8 short reset ignored");
    expect_at(n0, A + 10, 1'b1, "R8 still high later");
    settle();

    // R7 and R9: four-cycle reset takes effect, then minimum low time
    n0 = ncyc;
    rst_n = 1'b0;
    expect_at(n0, 6, 1'b1, "R7 before reset takes effect");
    expect_at(n0, 7, 1'b0, "R7 reset forces low");
    wait_n(4);
    n1 = ncyc;
    rst_n = 1'b1;
    expect_at(n1, A + 2, 1'b0, "R9 one edge early");
    expect_at(n1, A + 3, 1'b1, "R9 rises after full window");
    settle();

    wait_n(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule